// File: doc/BRIEF.md
# Privilege Mode and Interruption Entry Controller

This block holds the processor's two-bit status word, which carries the privilege mode and the interrupt enable. It also holds the registers that an interruption handler needs: a saved instruction address, a saved status word, an 8-bit parameter that describes the event, and the vector address where handlers begin. Each cycle it looks at the pending synchronous exception, the timer and I/O interrupt lines, and the control requests from the instruction that is executing. It then takes at most one action.

On an interruption it saves the resume address and the status word, records the cause, drops to kernel mode with interrupts disabled, and tells the fetch stage in the same cycle to continue at the vector. A return request made in kernel mode restores the saved status and sends fetch back to the saved address. A privileged request made in user mode has no effect of its own. It is flagged and turned into an exception.

Top module: `priv_trap_unit`

## Requirements
- R1: After a synchronous reset the status word is 2'b00 (kernel, interrupts disabled), the vector register holds the parameter RESET_VEC, the saved address, saved status and parameter register are zero, and redirect_o is low.
- R2: Status bit 0 is the mode (0 kernel, 1 user) and bit 1 is the interrupt enable. In kernel mode, a write with wr_sel_i=0 loads wr_data_i[1:0] into the status word, and a write with wr_sel_i=1 loads wr_data_i into the vector register. Both take effect on the next clock edge.
- R3: Every interruption entry, whether exception, privilege violation, timer or I/O, sets the status word to 2'b00 at the next edge.
- R4: On entry, the saved-address register captures cur_ia_i.
- R5: On entry, the saved-status register captures the current status word. The parameter register captures {1'b0, class[2:0], cause[3:0]}, where the class is 1 for an external exception (cause = exc_cause_i), 2 for a privilege violation (cause = {1'b0, rti_i, wr_en_i, priv_op_i}), 3 for the timer (cause 0) and 4 for I/O (cause = io_id_i).
- R6: In the cycle of an entry, redirect_o is high and redirect_addr_o equals the vector register.
- R7: In user mode, priv_op_i, wr_en_i or rti_i raises priv_fault_o in the same cycle and causes a privilege-violation entry. The write or return itself has no effect.
- R8: Timer and I/O interrupts are taken only while the interrupt enable bit is 1. Exceptions are taken whatever its value.
- R9: A return request in kernel mode, when nothing of higher priority is pending, raises redirect_o with redirect_addr_o equal to the saved address, and loads the saved status into the status word at the next edge.
- R10: Only one action is taken per cycle, in this priority order: external exception, privilege violation, timer, I/O, return, write.
- R11: In a cycle with no entry, no return and no write, the status word, saved address, saved status, parameter and vector registers all hold their values, and redirect_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_ia_i | input | AW | Address at which execution resumes after an interruption |
| exc_req_i | input | 1 | Synchronous exception pending |
| exc_cause_i | input | 4 | Cause code of the exception |
| irq_timer_i | input | 1 | Interval timer interrupt request (level) |
| irq_io_i | input | 1 | I/O interrupt request (level) |
| io_id_i | input | 4 | Identifier of the requesting I/O source |
| priv_op_i | input | 1 | Current instruction is a privileged operation (halt, direct I/O, base/bound/timer load) |
| rti_i | input | 1 | Return-from-interruption request |
| wr_en_i | input | 1 | Control register write request |
| wr_sel_i | input | 1 | Write target: 0 status word, 1 vector register |
| wr_data_i | input | AW | Write data |
| redirect_o | output | 1 | Fetch must continue at redirect_addr_o |
| redirect_addr_o | output | AW | Redirect target |
| psw_o | output | 2 | Status word: bit 1 interrupt enable, bit 0 mode |
| iva_o | output | AW | Vector address register |
| iia_o | output | AW | Saved instruction address |
| ipsw_o | output | 2 | Saved status word |
| ip_o | output | 8 | Interruption parameter |
| priv_fault_o | output | 1 | Privileged request seen in user mode |

## Verification
The bench builds the block with AW=16 and RESET_VEC=16'h0040. A 16-bit address lets random resume addresses and vector writes reach the full range of the register fields. A non-zero reset vector shows that the reset value really comes from the parameter and is not left at zero. Random status writes move the block between user and kernel mode with the enable both on and off, so masked interrupts, user-mode faults that collide with interrupts, and returns that lose to an interrupt all occur many times alongside the directed cases.

// File: rtl/priv_trap_pkg.sv
package priv_trap_pkg;

    localparam int CAUSE_W = 4;
    localparam int CLASS_W = 3;
    localparam int IP_W    = 1 + CLASS_W + CAUSE_W;

    // bit 1: interrupt enable, bit 0: mode (1 = user)
    typedef struct packed {
        logic ie;
        logic user;
    } psw_t;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_EXC,
        EV_PRIV,
        EV_TIMER,
        EV_IO,
        EV_RTI,
        EV_WRITE
    } ev_e;

    localparam logic [CLASS_W-1:0] CL_EXC   = 3'd1;
    localparam logic [CLASS_W-1:0] CL_PRIV  = 3'd2;
    localparam logic [CLASS_W-1:0] CL_TIMER = 3'd3;
    localparam logic [CLASS_W-1:0] CL_IO    = 3'd4;

    function automatic logic [IP_W-1:0] pack_ip(input logic [CLASS_W-1:0] cl,
                                                input logic [CAUSE_W-1:0] cause);
        return {1'b0, cl, cause};
    endfunction

    function automatic logic is_entry(input ev_e e);
        return (e == EV_EXC) || (e == EV_PRIV) || (e == EV_TIMER) || (e == EV_IO);
    endfunction

endpackage

// File: rtl/priv_trap_arb.sv
module priv_trap_arb
    import priv_trap_pkg::*;
(
    input  psw_t                 psw,
    input  logic                 exc_req,
    input  logic [CAUSE_W-1:0]   exc_cause,
    input  logic                 irq_timer,
    input  logic                 irq_io,
    input  logic [CAUSE_W-1:0]   io_id,
    input  logic                 priv_op,
    input  logic                 wr_en,
    input  logic                 rti,
    output ev_e                  ev,
    output logic [IP_W-1:0]      ip_code,
    output logic                 fault
);

    always_comb begin
        fault   = psw.user && (priv_op || wr_en || rti);
        ev      = EV_NONE;
        ip_code = '0;
        if (exc_req) begin
            ev      = EV_EXC;
            ip_code = pack_ip(CL_EXC, exc_cause);
        end else if (fault) begin
            ev      = EV_PRIV;
            ip_code = pack_ip(CL_PRIV, {1'b0, rti, wr_en, priv_op});
        end else if (psw.ie && irq_timer) begin
            ev      = EV_TIMER;
            ip_code = pack_ip(CL_TIMER, '0);
        end else if (psw.ie && irq_io) begin
            ev      = EV_IO;
            ip_code = pack_ip(CL_IO, io_id);
        end else if (rti) begin
            ev = EV_RTI;
        end else if (wr_en) begin
            ev = EV_WRITE;
        end
    end

endmodule

// File: rtl/priv_trap_regs.sv
module priv_trap_regs
    import priv_trap_pkg::*;
#(
    parameter int             AW        = 32,
    parameter logic [AW-1:0]  RESET_VEC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  ev_e               ev,
    input  logic [IP_W-1:0]   ip_code,
    input  logic [AW-1:0]     cur_ia,
    input  logic              wr_sel,
    input  logic [AW-1:0]     wr_data,
    output psw_t              psw,
    output logic [AW-1:0]     iva,
    output logic [AW-1:0]     iia,
    output psw_t              ipsw,
    output logic [IP_W-1:0]   ip
);

    always_ff @(posedge clk) begin
        if (rst) begin
            psw  <= '0;
            iva  <= RESET_VEC;
            iia  <= '0;
            ipsw <= '0;
            ip   <= '0;
        end else begin
            if (is_entry(ev)) begin
                iia  <= cur_ia;
                ipsw <= psw;
                ip   <= ip_code;
                psw  <= '0;
            end else if (ev == EV_RTI) begin
                psw <= ipsw;
            end else if (ev == EV_WRITE) begin
                if (wr_sel) iva <= wr_data;
                else        psw <= psw_t'(wr_data[1:0]);
            end
        end
    end

endmodule

// File: rtl/priv_trap_unit.sv
module priv_trap_unit
    import priv_trap_pkg::*;
#(
    parameter int             AW        = 32,
    parameter logic [AW-1:0]  RESET_VEC = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [AW-1:0]  cur_ia_i,
    input  logic           exc_req_i,
    input  logic [3:0]     exc_cause_i,
    input  logic           irq_timer_i,
    input  logic           irq_io_i,
    input  logic [3:0]     io_id_i,
    input  logic           priv_op_i,
    input  logic           rti_i,
    input  logic           wr_en_i,
    input  logic           wr_sel_i,
    input  logic [AW-1:0]  wr_data_i,
    output logic           redirect_o,
    output logic [AW-1:0]  redirect_addr_o,
    output logic [1:0]     psw_o,
    output logic [AW-1:0]  iva_o,
    output logic [AW-1:0]  iia_o,
    output logic [1:0]     ipsw_o,
    output logic [7:0]     ip_o,
    output logic           priv_fault_o
);

    psw_t             psw_q;
    psw_t             ipsw_q;
    ev_e              ev_w;
    logic [IP_W-1:0]  ip_code_w;
    logic             entry_w;
    logic             rti_take_w;
    logic             wr_take_w;

    priv_trap_arb u_arb (
        .psw       (psw_q),
        .exc_req   (exc_req_i),
        .exc_cause (exc_cause_i),
        .irq_timer (irq_timer_i),
        .irq_io    (irq_io_i),
        .io_id     (io_id_i),
        .priv_op   (priv_op_i),
        .wr_en     (wr_en_i),
        .rti       (rti_i),
        .ev        (ev_w),
        .ip_code   (ip_code_w),
        .fault     (priv_fault_o)
    );

    priv_trap_regs #(.AW(AW), .RESET_VEC(RESET_VEC)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev_w),
        .ip_code (ip_code_w),
        .cur_ia  (cur_ia_i),
        .wr_sel  (wr_sel_i),
        .wr_data (wr_data_i),
        .psw     (psw_q),
        .iva     (iva_o),
        .iia     (iia_o),
        .ipsw    (ipsw_q),
        .ip      (ip_o)
    );

    assign entry_w    = is_entry(ev_w);
    assign rti_take_w = (ev_w == EV_RTI);
    assign wr_take_w  = (ev_w == EV_WRITE);

    always_comb begin
        redirect_o      = entry_w || rti_take_w;
        redirect_addr_o = rti_take_w ? iia_o : iva_o;
    end

    assign psw_o  = psw_q;
    assign ipsw_o = ipsw_q;

endmodule

// File: rtl/priv_trap_chk.sv
module priv_trap_chk #(
    parameter int AW = 32
) (
    input logic           clk,
    input logic           rst,
    input logic           entry,
    input logic           rti_take,
    input logic           wr_take,
    input logic           exc_req,
    input logic           wr_en,
    input logic           redirect,
    input logic [AW-1:0]  redirect_addr,
    input logic [AW-1:0]  cur_ia,
    input logic [1:0]     psw,
    input logic [1:0]     ipsw,
    input logic [AW-1:0]  iia,
    input logic [AW-1:0]  iva,
    input logic           fault
);

    p_entry_kernel_r3: assert property (@(posedge clk) disable iff (rst)
        entry |=> psw == 2'b00);

    p_save_ia_r4: assert property (@(posedge clk) disable iff (rst)
        entry |=> iia == $past(cur_ia));

    p_save_psw_r5: assert property (@(posedge clk) disable iff (rst)
        entry |=> ipsw == $past(psw));

    p_vector_r6: assert property (@(posedge clk) disable iff (rst)
        entry |-> (redirect && redirect_addr == iva));

    p_user_write_faults_r7: assert property (@(posedge clk) disable iff (rst)
        (psw[0] && wr_en) |-> (fault && !wr_take));

    p_masked_r8: assert property (@(posedge clk) disable iff (rst)
        (!psw[1] && !exc_req && !fault) |-> !entry);

    p_rti_restore_r9: assert property (@(posedge clk) disable iff (rst)
        rti_take |=> psw == $past(ipsw));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (!entry && !rti_take && !wr_take) |=> ($stable(psw) && $stable(ipsw) && $stable(iia)));

endmodule

bind priv_trap_unit priv_trap_chk #(.AW(AW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .entry         (entry_w),
    .rti_take      (rti_take_w),
    .wr_take       (wr_take_w),
    .exc_req       (exc_req_i),
    .wr_en         (wr_en_i),
    .redirect      (redirect_o),
    .redirect_addr (redirect_addr_o),
    .cur_ia        (cur_ia_i),
    .psw           (psw_o),
    .ipsw          (ipsw_o),
    .iia           (iia_o),
    .iva           (iva_o),
    .fault         (priv_fault_o)
);

// File: tb/priv_trap_unit_bench.sv
module priv_trap_unit_bench;

    localparam int AW = 16;
    localparam logic [AW-1:0] RVEC = 16'h0040;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [AW-1:0]  cur_ia = '0;
    logic           exc_req = 0;
    logic [3:0]     exc_cause = 0;
    logic           irq_timer = 0;
    logic           irq_io = 0;
    logic [3:0]     io_id = 0;
    logic           priv_op = 0;
    logic           rti = 0;
    logic           wr_en = 0;
    logic           wr_sel = 0;
    logic [AW-1:0]  wr_data = '0;
    logic           redirect;
    logic [AW-1:0]  redirect_addr;
    logic [1:0]     psw;
    logic [AW-1:0]  iva;
    logic [AW-1:0]  iia;
    logic [1:0]     ipsw;
    logic [7:0]     ip;
    logic           fault;

    priv_trap_unit #(.AW(AW), .RESET_VEC(RVEC)) u_priv_trap_unit (
        .clk(clk), .rst(rst), .cur_ia_i(cur_ia), .exc_req_i(exc_req),
        .exc_cause_i(exc_cause), .irq_timer_i(irq_timer), .irq_io_i(irq_io),
        .io_id_i(io_id), .priv_op_i(priv_op), .rti_i(rti), .wr_en_i(wr_en),
        .wr_sel_i(wr_sel), .wr_data_i(wr_data), .redirect_o(redirect),
        .redirect_addr_o(redirect_addr), .psw_o(psw), .iva_o(iva), .iia_o(iia),
        .ipsw_o(ipsw), .ip_o(ip), .priv_fault_o(fault)
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    int m_psw, m_ipsw, m_iva, m_iia, m_ip;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // one cycle: drive, compare against model, advance model
    task automatic step(input bit e, input int ec, input bit t, input bit io,
                        input int id, input bit po, input bit r, input bit w,
                        input bit ws, input int wd, input int ia);
        int kind;   // 0 none 1 exc 2 priv 3 timer 4 io 5 rti 6 write
        int code;
        bit flt, user, ie;
        int e_red, e_addr;
        @(negedge clk);
        exc_req = e; exc_cause = 4'(ec); irq_timer = t; irq_io = io;
        io_id = 4'(id); priv_op = po; rti = r; wr_en = w; wr_sel = ws;
        wr_data = AW'(wd); cur_ia = AW'(ia);
        #1;
        user = m_psw[0];
        ie   = m_psw[1];
        flt  = user && (po || w || r);
        kind = 0; code = 0;
        if (e)              begin kind = 1; code = 16 + (ec & 15); end
        else if (flt)       begin kind = 2; code = 32 + (r ? 4 : 0) + (w ? 2 : 0) + (po ? 1 : 0); end
        else if (ie && t)   begin kind = 3; code = 48; end
        else if (ie && io)  begin kind = 4; code = 64 + (id & 15); end
        else if (r)         kind = 5;
        else if (w)         kind = 6;
        e_red  = (kind >= 1 && kind <= 5) ? 1 : 0;
        e_addr = (kind == 5) ? m_iia : m_iva;
        chk(fault == flt, "R7", "priv_fault", int'(fault), int'(flt));
        chk(redirect == e_red[0], "R6/R9/R11", "redirect", int'(redirect), e_red);
        if (e_red != 0)
            chk(int'(redirect_addr) == e_addr, (kind == 5) ? "R9" : "R6",
                "redirect_addr", int'(redirect_addr), e_addr);
        chk(int'(psw) == m_psw, "R2/R3/R9", "psw", int'(psw), m_psw);
        chk(int'(iia) == m_iia, "R4", "iia", int'(iia), m_iia);
        chk(int'(ipsw) == m_ipsw, "R5", "ipsw", int'(ipsw), m_ipsw);
        chk(int'(ip) == m_ip, "R5/R10", "ip", int'(ip), m_ip);
        chk(int'(iva) == m_iva, "R2/R11", "iva", int'(iva), m_iva);
        @(posedge clk);
        if (kind >= 1 && kind <= 4) begin
            m_iia = ia & 16'hFFFF; m_ipsw = m_psw; m_ip = code; m_psw = 0;
        end else if (kind == 5) begin
            m_psw = m_ipsw;
        end else if (kind == 6) begin
            if (ws) m_iva = wd & 16'hFFFF;
            else    m_psw = wd & 3;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        m_psw = 0; m_ipsw = 0; m_iva = int'(RVEC); m_iia = 0; m_ip = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R1: reset state, idle
        step(0,0,0,0,0,0,0,0,0,0,16'h1000);
        // R8: interrupts masked in kernel with ie=0
        step(0,0,1,1,3,0,0,0,0,0,16'h1004);
        // R2: write vector, then status = kernel + ie
        step(0,0,0,0,0,0,0,1,1,16'h0200,16'h1008);
        step(0,0,0,0,0,0,0,1,0,2,16'h100C);
        // R3/R4/R5/R6: timer entry
        step(0,0,1,1,5,0,0,0,0,0,16'h1010);
        // R9: return restores ie
        step(0,0,0,0,0,0,1,0,0,0,16'h0210);
        // enter user mode with ie
        step(0,0,0,0,0,0,0,1,0,3,16'h1014);
        // R7: privileged op in user mode
        step(0,0,0,0,0,1,0,0,0,0,16'h1018);
        step(0,0,0,0,0,0,1,0,0,0,16'h0220);
        // R7: user write of vector ignored, traps
        step(0,0,0,0,0,0,0,1,1,16'hBEEF,16'h101C);
        step(0,0,0,0,0,0,1,0,0,0,16'h0224);
        // R10: exception beats interrupt and fault
        step(1,9,1,1,2,1,0,0,0,0,16'h1020);
        // R10: return in kernel loses to I/O interrupt only when enabled
        step(0,0,0,1,7,0,1,0,0,0,16'h0228);
        // R11: idle hold
        step(0,0,0,0,0,0,0,0,0,0,16'h1024);
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 16) == 0, $urandom % 16, ($urandom % 4) == 0,
                 ($urandom % 4) == 0, $urandom % 16, ($urandom % 8) == 0,
                 ($urandom % 8) == 0, ($urandom % 4) == 0, $urandom % 2,
                 $urandom % 65536, $urandom % 65536);
        end
        finish_run();
    end

endmodule